// File: doc/BRIEF.md
# Signed Logarithmic Multiply-Divide Unit

This block does arithmetic on numbers held in a signed logarithmic format. Each operand has three parts: a sign bit, a zero flag, and a fixed-point base-2 logarithm of the magnitude. The logarithm is a 20-bit two's-complement field with 12 fraction bits, so `0x01000` stands for a magnitude of 2. In this format the costly linear operations become cheap ones in the log domain. A product or quotient is an add or subtract of the logs plus an XOR of the signs. A square is a one-bit left shift of the log. A reciprocal is a negation of the log. A square root is a one-bit arithmetic right shift of the log.

Requests come in on a valid/ready stream with an opcode and two operands. Each accepted request produces exactly one registered result, one cycle later, on an output valid/ready stream. The unit accepts a new request in any cycle in which its output register is empty or is being drained in that same cycle. When the consumer holds `out_ready` low, the result and all its flags stay frozen. New requests are then refused until the result is taken. A log result that falls outside the 20-bit range is clamped and flagged. The exceptional cases are the value zero, a reciprocal or division by zero, the root of a negative number, and an unknown opcode. Each of these produces a clean zero result with its own flag.

Top module: `lns_muldiv`

## Requirements
- R1: Opcode 0 (multiply) returns log = a_log + b_log and sign = a_sign XOR b_sign when neither operand is zero.
- R2: Opcode 1 (divide) returns log = a_log - b_log and sign = a_sign XOR b_sign when neither operand is zero.
- R3: Opcode 2 (square) returns log = 2 * a_log with sign 0. The b operand is ignored.
- R4: Opcode 3 (reciprocal) returns log = -a_log with the sign of a unchanged. The reciprocal of log `0x80000` saturates to `0x7FFFF` and raises overflow.
- R5: Opcode 4 (square root) returns a_log shifted right by one bit arithmetically (rounding toward minus infinity), with sign 0. For a non-zero operand with sign 1 it instead raises invalid and returns zero.
- R6: A log result above `0x7FFFF` or below `0x80000` (signed) is clamped to that bound and raises out_ovf.
- R7: A zero result is presented as out_zero=1, out_log=0, out_sign=0 and out_ovf=0. It occurs for a multiply with either operand zero, a divide with a zero dividend, and a square or square root of zero. In these cases the log and sign of a zero operand have no effect.
- R8: A divide whose divisor is zero, or a reciprocal of zero, raises out_err and returns zero.
- R9: Opcodes 5, 6 and 7 raise out_inv and return zero.
- R10: in_ready equals (!out_valid || out_ready). A request accepted at one clock edge is presented at the next edge. While out_valid is high and out_ready is low, every output field holds its value.
- R11: After reset, out_valid is 0 and in_ready is 1.
- R12: At most one of out_ovf, out_err and out_inv is set in any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_op | input | 3 | Opcode: 0 mul, 1 div, 2 square, 3 reciprocal, 4 square root |
| a_sign | input | 1 | Sign of operand a (1 = negative) |
| a_zero | input | 1 | Operand a is zero |
| a_log | input | 20 | Log of the magnitude of a, two's complement, 12 fraction bits |
| b_sign | input | 1 | Sign of operand b |
| b_zero | input | 1 | Operand b is zero |
| b_log | input | 20 | Log of the magnitude of b |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sign | output | 1 | Result sign |
| out_zero | output | 1 | Result is zero |
| out_log | output | 20 | Result log |
| out_ovf | output | 1 | Result log was clamped |
| out_err | output | 1 | Division by zero or reciprocal of zero |
| out_inv | output | 1 | Root of a negative number or unknown opcode |

## Verification
The properties assume the producer holds in_op and both operands steady whenever they are sampled with in_valid high. They also assume that a_log and b_log are meaningful only when the matching zero flag is low. The stimulus changes inputs only at falling edges and drives junk log and sign values behind set zero flags, so the zero path is tested against data it must ignore. Back-pressure is exercised by holding out_ready low across several edges while a second request waits. Both the frozen output and the refused request can then be seen at the ports.

// File: rtl/lns_md_pkg.sv
package lns_md_pkg;

  // Opcodes seen on in_op
  localparam logic [2:0] OPC_MUL  = 3'd0;
  localparam logic [2:0] OPC_DIV  = 3'd1;
  localparam logic [2:0] OPC_SQR  = 3'd2;
  localparam logic [2:0] OPC_RCP  = 3'd3;
  localparam logic [2:0] OPC_SQRT = 3'd4;

  // Operation performed on the log fields
  typedef enum logic [2:0] {
    LK_ADD  = 3'd0,
    LK_SUB  = 3'd1,
    LK_DBL  = 3'd2,
    LK_NEG  = 3'd3,
    LK_HALF = 3'd4,
    LK_NONE = 3'd5
  } log_kind_e;

  typedef struct packed {
    logic ovf;
    logic err;
    logic inv;
  } exc_flags_t;

endpackage

// File: rtl/lns_log_alu.sv
module lns_log_alu
  import lns_md_pkg::*;
#(
  parameter int LOG_W = 20
) (
  input  log_kind_e        kind,
  input  logic [LOG_W-1:0] x_log,
  input  logic [LOG_W-1:0] y_log,
  output logic [LOG_W-1:0] r_log,
  output logic             r_ovf
);

  // Two guard bits keep every operation exact before clamping
  localparam int WX = LOG_W + 2;
  localparam logic signed [WX-1:0] HI_LIM = {3'b000, {(LOG_W-1){1'b1}}};
  localparam logic signed [WX-1:0] LO_LIM = {3'b111, {(LOG_W-1){1'b0}}};
  localparam logic [LOG_W-1:0] HI_CODE = {1'b0, {(LOG_W-1){1'b1}}};
  localparam logic [LOG_W-1:0] LO_CODE = {1'b1, {(LOG_W-1){1'b0}}};

  logic signed [WX-1:0] xe, ye, wide;

  always_comb begin
    xe = $signed({{2{x_log[LOG_W-1]}}, x_log});
    ye = $signed({{2{y_log[LOG_W-1]}}, y_log});
    unique case (kind)
      LK_ADD:  wide = xe + ye;
      LK_SUB:  wide = xe - ye;
      LK_DBL:  wide = $signed({xe[WX-2:0], 1'b0});
      LK_NEG:  wide = -xe;
      LK_HALF: wide = xe >>> 1;
      default: wide = '0;
    endcase
  end

  always_comb begin
    if (wide > HI_LIM) begin
      r_log = HI_CODE;
      r_ovf = 1'b1;
    end else if (wide < LO_LIM) begin
      r_log = LO_CODE;
      r_ovf = 1'b1;
    end else begin
      r_log = wide[LOG_W-1:0];
      r_ovf = 1'b0;
    end
  end

endmodule

// File: rtl/lns_sign_ctrl.sv
module lns_sign_ctrl
  import lns_md_pkg::*;
(
  input  logic [2:0] op,
  input  logic       a_sign,
  input  logic       a_zero,
  input  logic       b_sign,
  input  logic       b_zero,
  output log_kind_e  kind,
  output logic       r_sign,
  output logic       force_zero,
  output logic       r_err,
  output logic       r_inv
);

  always_comb begin
    kind       = LK_NONE;
    r_sign     = 1'b0;
    force_zero = 1'b0;
    r_err      = 1'b0;
    r_inv      = 1'b0;
    unique case (op)
      OPC_MUL: begin
        kind       = LK_ADD;
        r_sign     = a_sign ^ b_sign;
        force_zero = a_zero | b_zero;
      end
      OPC_DIV: begin
        kind       = LK_SUB;
        r_sign     = a_sign ^ b_sign;
        r_err      = b_zero;
        force_zero = a_zero | b_zero;
      end
      OPC_SQR: begin
        kind       = LK_DBL;
        force_zero = a_zero;
      end
      OPC_RCP: begin
        kind       = LK_NEG;
        r_sign     = a_sign;
        r_err      = a_zero;
        force_zero = a_zero;
      end
      OPC_SQRT: begin
        kind       = LK_HALF;
        r_inv      = a_sign & ~a_zero;
        force_zero = a_zero | (a_sign & ~a_zero);
      end
      default: begin
        r_inv      = 1'b1;
        force_zero = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/lns_out_stage.sv
module lns_out_stage
  import lns_md_pkg::*;
#(
  parameter int LOG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drain,
  input  logic             d_sign,
  input  logic             d_zero,
  input  logic [LOG_W-1:0] d_log,
  input  exc_flags_t       d_flags,
  output logic             q_valid,
  output logic             q_sign,
  output logic             q_zero,
  output logic [LOG_W-1:0] q_log,
  output exc_flags_t       q_flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_sign  <= 1'b0;
      q_zero  <= 1'b0;
      q_log   <= '0;
      q_flags <= '0;
    end else begin
      if (load) begin
        q_valid <= 1'b1;
        q_sign  <= d_sign;
        q_zero  <= d_zero;
        q_log   <= d_log;
        q_flags <= d_flags;
      end else if (drain) begin
        q_valid <= 1'b0;
      end
    end
  end

  // R10: a stalled result stays put
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !drain |=> q_valid && $stable(q_log) && $stable(q_sign)
                          && $stable(q_zero) && $stable(q_flags));

endmodule

// File: rtl/lns_muldiv.sv
module lns_muldiv
  import lns_md_pkg::*;
#(
  parameter int LOG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic             a_sign,
  input  logic             a_zero,
  input  logic [LOG_W-1:0] a_log,
  input  logic             b_sign,
  input  logic             b_zero,
  input  logic [LOG_W-1:0] b_log,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sign,
  output logic             out_zero,
  output logic [LOG_W-1:0] out_log,
  output logic             out_ovf,
  output logic             out_err,
  output logic             out_inv
);

  localparam logic [LOG_W-1:0] HI_CODE = {1'b0, {(LOG_W-1){1'b1}}};
  localparam logic [LOG_W-1:0] LO_CODE = {1'b1, {(LOG_W-1){1'b0}}};

  log_kind_e        kind;
  logic             c_sign, c_zero, c_err, c_inv;
  logic [LOG_W-1:0] alu_log;
  logic             alu_ovf;
  logic             accept;
  logic             d_sign;
  logic [LOG_W-1:0] d_log;
  exc_flags_t       d_flags, q_flags;

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  lns_sign_ctrl u_ctrl (
    .op         (in_op),
    .a_sign     (a_sign),
    .a_zero     (a_zero),
    .b_sign     (b_sign),
    .b_zero     (b_zero),
    .kind       (kind),
    .r_sign     (c_sign),
    .force_zero (c_zero),
    .r_err      (c_err),
    .r_inv      (c_inv)
  );

  lns_log_alu #(.LOG_W(LOG_W)) u_alu (
    .kind  (kind),
    .x_log (a_log),
    .y_log (b_log),
    .r_log (alu_log),
    .r_ovf (alu_ovf)
  );

  // A zero result overrides log, sign and clamping
  always_comb begin
    if (c_zero) begin
      d_sign  = 1'b0;
      d_log   = '0;
      d_flags = '{ovf: 1'b0, err: c_err, inv: c_inv};
    end else begin
      d_sign  = c_sign;
      d_log   = alu_log;
      d_flags = '{ovf: alu_ovf, err: 1'b0, inv: 1'b0};
    end
  end

  lns_out_stage #(.LOG_W(LOG_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .drain   (out_ready),
    .d_sign  (d_sign),
    .d_zero  (c_zero),
    .d_log   (d_log),
    .d_flags (d_flags),
    .q_valid (out_valid),
    .q_sign  (out_sign),
    .q_zero  (out_zero),
    .q_log   (out_log),
    .q_flags (q_flags)
  );

  assign out_ovf = q_flags.ovf;
  assign out_err = q_flags.err;
  assign out_inv = q_flags.inv;

  // R10: one cycle from acceptance to presentation
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R1: product sign is the XOR of the operand signs
  a_r1_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OPC_MUL && !a_zero && !b_zero
      |=> out_sign == $past(a_sign ^ b_sign));

  // R3: an unclamped square has an even log and positive sign
  a_r3_square_even: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OPC_SQR && !a_zero
      |=> !out_sign && (out_ovf || !out_log[0]));

  // R4: reciprocal keeps the sign
  a_r4_rcp_sign: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OPC_RCP && !a_zero |=> out_sign == $past(a_sign));

  // R5: root of a negative non-zero operand is invalid
  a_r5_neg_root: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OPC_SQRT && a_sign && !a_zero |=> out_inv && out_zero);

  // R6: clamped logs sit exactly on a bound
  a_r6_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> (out_log == HI_CODE || out_log == LO_CODE));

  // R7: zero results are canonical
  a_r7_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero |-> out_log == '0 && !out_sign && !out_ovf);

  // R8: errors and invalids always come with a zero value
  a_r8_exc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_err || out_inv) |-> out_zero);

  // R12: exception flags are exclusive
  a_r12_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_ovf, out_err, out_inv}));

endmodule

// File: tb/lns_muldiv_tb.sv
module lns_muldiv_tb;

  localparam int LOG_W = 20;
  localparam int NV    = 23;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [2:0]       in_op = '0;
  logic             a_sign = 1'b0, a_zero = 1'b0;
  logic [LOG_W-1:0] a_log = '0;
  logic             b_sign = 1'b0, b_zero = 1'b0;
  logic [LOG_W-1:0] b_log = '0;
  logic             out_valid, out_ready = 1'b1;
  logic             out_sign, out_zero, out_ovf, out_err, out_inv;
  logic [LOG_W-1:0] out_log;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lns_muldiv #(.LOG_W(LOG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .a_sign(a_sign), .a_zero(a_zero), .a_log(a_log),
    .b_sign(b_sign), .b_zero(b_zero), .b_log(b_log),
    .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
    .out_zero(out_zero), .out_log(out_log), .out_ovf(out_ovf),
    .out_err(out_err), .out_inv(out_inv)
  );

  // {req, op, as, az, alog, bs, bz, blog, es, ez, elog, {ovf,err,inv}}
  localparam logic [75:0] VEC [NV] = '{
    {4'd1, 3'd0, 1'b0,1'b0,20'h01000, 1'b1,1'b0,20'h02000, 1'b1,1'b0,20'h03000, 3'b000}, // R1
    {4'd1, 3'd0, 1'b1,1'b0,20'hFF000, 1'b1,1'b0,20'h00800, 1'b0,1'b0,20'hFF800, 3'b000}, // R1
    {4'd6, 3'd0, 1'b0,1'b0,20'h7F000, 1'b0,1'b0,20'h02000, 1'b0,1'b0,20'h7FFFF, 3'b100}, // R6
    {4'd6, 3'd0, 1'b1,1'b0,20'h80000, 1'b0,1'b0,20'hFFFFF, 1'b1,1'b0,20'h80000, 3'b100}, // R6
    {4'd2, 3'd1, 1'b0,1'b0,20'h03000, 1'b1,1'b0,20'h01000, 1'b1,1'b0,20'h02000, 3'b000}, // R2
    {4'd6, 3'd1, 1'b0,1'b0,20'h7FFFF, 1'b0,1'b0,20'hFFFFF, 1'b0,1'b0,20'h7FFFF, 3'b100}, // R6
    {4'd8, 3'd1, 1'b0,1'b0,20'h01000, 1'b1,1'b1,20'h05555, 1'b0,1'b1,20'h00000, 3'b010}, // R8
    {4'd7, 3'd1, 1'b1,1'b1,20'h0ABCD, 1'b0,1'b0,20'h01000, 1'b0,1'b1,20'h00000, 3'b000}, // R7
    {4'd3, 3'd2, 1'b1,1'b0,20'h01800, 1'b1,1'b0,20'h7FFFF, 1'b0,1'b0,20'h03000, 3'b000}, // R3
    {4'd3, 3'd2, 1'b0,1'b0,20'hFF000, 1'b0,1'b1,20'h00000, 1'b0,1'b0,20'hFE000, 3'b000}, // R3
    {4'd6, 3'd2, 1'b0,1'b0,20'h40000, 1'b0,1'b0,20'h00000, 1'b0,1'b0,20'h7FFFF, 3'b100}, // R6
    {4'd7, 3'd2, 1'b1,1'b1,20'h01234, 1'b0,1'b0,20'h00000, 1'b0,1'b1,20'h00000, 3'b000}, // R7
    {4'd4, 3'd3, 1'b1,1'b0,20'h01234, 1'b0,1'b0,20'h00000, 1'b1,1'b0,20'hFEDCC, 3'b000}, // R4
    {4'd4, 3'd3, 1'b0,1'b0,20'h80000, 1'b0,1'b0,20'h00000, 1'b0,1'b0,20'h7FFFF, 3'b100}, // R4
    {4'd8, 3'd3, 1'b0,1'b1,20'h00000, 1'b0,1'b0,20'h00000, 1'b0,1'b1,20'h00000, 3'b010}, // R8
    {4'd5, 3'd4, 1'b0,1'b0,20'h02000, 1'b0,1'b0,20'h00000, 1'b0,1'b0,20'h01000, 3'b000}, // R5
    {4'd5, 3'd4, 1'b0,1'b0,20'hFFFFF, 1'b0,1'b0,20'h00000, 1'b0,1'b0,20'hFFFFF, 3'b000}, // R5
    {4'd5, 3'd4, 1'b0,1'b0,20'h00003, 1'b0,1'b0,20'h00000, 1'b0,1'b0,20'h00001, 3'b000}, // R5
    {4'd5, 3'd4, 1'b1,1'b0,20'h02000, 1'b0,1'b0,20'h00000, 1'b0,1'b1,20'h00000, 3'b001}, // R5
    {4'd7, 3'd4, 1'b1,1'b1,20'h02000, 1'b0,1'b0,20'h00000, 1'b0,1'b1,20'h00000, 3'b000}, // R7
    {4'd9, 3'd5, 1'b0,1'b0,20'h01000, 1'b0,1'b0,20'h01000, 1'b0,1'b1,20'h00000, 3'b001}, // R9
    {4'd7, 3'd0, 1'b0,1'b0,20'h01000, 1'b1,1'b1,20'h7FFFF, 1'b0,1'b1,20'h00000, 3'b000}, // R7
    {4'd9, 3'd7, 1'b1,1'b0,20'h00400, 1'b0,1'b0,20'h00400, 1'b0,1'b1,20'h00000, 3'b001}  // R9
  };

  function automatic logic [24:0] got_bits();
    return {out_sign, out_zero, out_log, out_ovf, out_err, out_inv};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [75:0] v);
    in_op  = v[71:69];
    a_sign = v[68];
    a_zero = v[67];
    a_log  = v[66:47];
    b_sign = v[46];
    b_zero = v[45];
    b_log  = v[44:25];
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid == 1'b0, "R11 out_valid", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R11 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      drive(v);
      in_valid  = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      check(out_valid && got_bits() == v[24:0],
            $sformatf("R%0d vector %0d", v[75:72], i),
            {6'd0, out_valid, got_bits()}, {7'd1, v[24:0]});
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 drains when idle", {31'd0, out_valid}, 32'd0);

    // R10: back-pressure holds the result and refuses new work
    out_ready = 1'b0;
    drive(VEC[0]);
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && got_bits() == VEC[0][24:0], "R10 first result",
          {7'd0, got_bits()}, {7'd0, VEC[0][24:0]});
    check(in_ready == 1'b0, "R10 in_ready low when stalled",
          {31'd0, in_ready}, 32'd0);
    drive(VEC[4]);
    repeat (3) @(negedge clk);
    check(out_valid && got_bits() == VEC[0][24:0], "R10 held while stalled",
          {7'd0, got_bits()}, {7'd0, VEC[0][24:0]});
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid && got_bits() == VEC[4][24:0], "R10 second result after drain",
          {7'd0, got_bits()}, {7'd0, VEC[4][24:0]});
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 empty after drain", {31'd0, out_valid}, 32'd0);

    // R12: flags exclusive on a clamped divide
    drive(VEC[5]);
    in_valid = 1'b1;
    @(negedge clk);
    check($countones({out_ovf, out_err, out_inv}) == 1 && out_ovf,
          "R12 single flag", {29'd0, out_ovf, out_err, out_inv}, 32'd4);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule